// File: doc/BRIEF.md
# Dual-Mode Pixel Output Formatter

This block takes a decoded video stream and re-times it onto a pair of 24-bit output buses, even and odd. The input carries one RGB pixel per clock, a data-enable that marks active video, horizontal and vertical sync, and three general control bits. In single-pixel mode every pixel leaves on the even bus, one per clock. In dual-pixel mode the block holds each even pixel until its odd partner arrives, then emits both together on one output beat, so the beat rate is half the input rate.

Around the datapath sit a few output-side controls. A clock enable marks the beats; it can run on every beat for continuously clocked panels, or only while the output data-enable is high for panels that expect a gated clock. In dual mode the odd bus can be staggered one input clock behind the even bus to spread switching current. A phase flag reports which output clock edge the data is meant for. An active-low power-down input drops the output enables of the main output group and leaves control bit 1 and the link-detect output enabled.

Top module: `dual_pixel_formatter`

## Requirements
- R1: While reset is high and on the first cycle after it, both pixel buses, out_de, out_hs, out_vs, out_ctl, out_valid and clk_en are zero.
- R2: With cfg_dual low, every input cycle produces a beat one clock later: out_valid is 1, even_bus equals the input pixel when in_de was 1 and zero when it was 0, out_de follows in_de, and odd_bus is zero.
- R3: With cfg_dual high, a beat occurs on at most every second input cycle. The beat that follows an odd pixel shows the even pixel that came just before it on even_bus and that odd pixel on odd_bus, one clock after the odd pixel was sampled, with out_de at 1. out_valid is 1 only in the cycle after a beat edge.
- R4: Pixel numbering restarts on each line: the first pixel sampled with in_de high after a cycle with in_de low is always held as an even pixel and never produces a beat on its own edge, whatever the beat phase during blank.
- R5: In dual mode, a line that ends on an even pixel emits that pixel on the next edge (the first blank cycle) with odd_bus zero and out_de at 1.
- R6: Beats taken during blank in dual mode occur on every second cycle and carry zero on both pixel buses with out_de at 0. On every beat, out_hs, out_vs and out_ctl are the input values sampled on the same edge as the beat; between beats all outputs hold.
- R7: clk_en equals out_valid when cfg_gate_de is low, and equals out_valid AND out_de when cfg_gate_de is high.
- R8: With cfg_dual high and cfg_stagger_n low, odd_bus shows the odd register value one input clock after the even bus changes; otherwise odd_bus changes in the same cycle as even_bus.
- R9: oe_main equals drv_pd_n (low during output power-down), while oe_keep stays high in every state.
- R10: phase_rise equals cfg_rise (1 means data is valid on the rising output clock edge, 0 the falling edge).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Input pixel clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_dual | input | 1 | 1 selects two pixels per beat, 0 one pixel per beat |
| cfg_gate_de | input | 1 | 1 gates clk_en with out_de, 0 lets it run on every beat |
| cfg_stagger_n | input | 1 | Active-low stagger of the odd bus, dual mode only |
| cfg_rise | input | 1 | Output clock edge select, 1 rising, 0 falling |
| drv_pd_n | input | 1 | Active-low output driver power-down |
| in_de | input | 1 | Input active-video enable |
| in_hs | input | 1 | Input horizontal sync |
| in_vs | input | 1 | Input vertical sync |
| in_ctl | input | 3 | Input control bits |
| in_pix | input | 24 | Input RGB pixel |
| even_bus | output | 24 | Even pixel output bus |
| odd_bus | output | 24 | Odd pixel output bus |
| out_valid | output | 1 | High in the cycle after a beat edge |
| out_de | output | 1 | Output active-video enable |
| out_hs | output | 1 | Output horizontal sync |
| out_vs | output | 1 | Output vertical sync |
| out_ctl | output | 3 | Output control bits |
| clk_en | output | 1 | Output clock enable |
| phase_rise | output | 1 | Output clock edge flag |
| oe_main | output | 1 | Output enable for pixels, syncs, DE, control bits 2 and 3 and the clock |
| oe_keep | output | 1 | Output enable for control bit 1 and the link-detect output |

## Verification
The hardest situation to reach is a rising in_de that arrives while the free-running blank beat phase is on its beat slot, because only then does the restart of pixel numbering decide whether the first pixel becomes even or wrongly odd; lines that end on an even pixel are the second awkward case. The stimulus gets there by drawing blank and line lengths at random from ranges that hold both odd and even values, so both phases meet both line parities many times, and it adds directed lines of one, two and three pixels after blanks of odd and even length.

// File: rtl/pxf_pkg.sv
package pxf_pkg;

    localparam int unsigned PIX_W = 24;
    localparam int unsigned CTL_W = 3;

    // One sampled input cycle.
    typedef struct packed {
        logic [PIX_W-1:0] pix;
        logic             de;
        logic             hs;
        logic             vs;
        logic [CTL_W-1:0] ctl;
    } pxf_in_t;

    // One output beat as held in the output registers.
    typedef struct packed {
        logic [PIX_W-1:0] even;
        logic [PIX_W-1:0] odd;
        logic             de;
        logic             hs;
        logic             vs;
        logic [CTL_W-1:0] ctl;
        logic             valid;
    } pxf_beat_t;

    function automatic logic [PIX_W-1:0] pix_or_zero(input logic en, input logic [PIX_W-1:0] p);
        return en ? p : '0;
    endfunction

endpackage

// File: rtl/pxf_pairer.sv
module pxf_pairer
    import pxf_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      dual,
    input  pxf_in_t   smp,
    output pxf_beat_t beat_q
);

    logic             ph_q;       // next cycle is a beat slot (dual mode)
    logic             prev_de_q;
    logic             hold_vld_q;
    logic [PIX_W-1:0] hold_q;
    logic             line_start;
    logic             beat_now;
    pxf_beat_t        beat_d;

    assign line_start = smp.de && !prev_de_q;
    assign beat_now   = !dual || (ph_q && !line_start);

    always_comb begin
        beat_d       = beat_q;
        beat_d.valid = beat_now;
        if (beat_now) begin
            beat_d.hs  = smp.hs;
            beat_d.vs  = smp.vs;
            beat_d.ctl = smp.ctl;
            if (!dual) begin
                beat_d.even = pix_or_zero(smp.de, smp.pix);
                beat_d.odd  = '0;
                beat_d.de   = smp.de;
            end else if (hold_vld_q) begin
                beat_d.even = hold_q;
                beat_d.odd  = pix_or_zero(smp.de, smp.pix);
                beat_d.de   = 1'b1;
            end else begin
                beat_d.even = '0;
                beat_d.odd  = '0;
                beat_d.de   = 1'b0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ph_q       <= 1'b0;
            prev_de_q  <= 1'b0;
            hold_vld_q <= 1'b0;
            hold_q     <= '0;
            beat_q     <= '0;
        end else begin
            prev_de_q <= smp.de;
            ph_q      <= dual ? !beat_now : 1'b0;
            beat_q    <= beat_d;
            if (beat_now) begin
                hold_vld_q <= 1'b0;
            end else if (smp.de) begin
                hold_q     <= smp.pix;
                hold_vld_q <= 1'b1;
            end
        end
    end

endmodule

// File: rtl/pxf_stagger.sv
module pxf_stagger
    import pxf_pkg::*;
#(
    parameter bit HAS_STAGGER = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             enable,
    input  logic [PIX_W-1:0] odd_in,
    output logic [PIX_W-1:0] odd_out
);

    generate
        if (HAS_STAGGER) begin : g_dly
            logic [PIX_W-1:0] dly_q;
            always_ff @(posedge clk) begin
                if (rst) dly_q <= '0;
                else     dly_q <= odd_in;
            end
            assign odd_out = enable ? dly_q : odd_in;
        end else begin : g_pass
            logic unused_ok;
            assign unused_ok = &{1'b0, clk, rst, enable};
            assign odd_out   = odd_in;
        end
    endgenerate

endmodule

// File: rtl/pxf_drive.sv
module pxf_drive (
    input  logic beat_vld,
    input  logic beat_de,
    input  logic gate_de,
    input  logic pd_n,
    input  logic rise_sel,
    output logic clk_en,
    output logic oe_main,
    output logic oe_keep,
    output logic phase_rise
);

    assign clk_en     = beat_vld && (!gate_de || beat_de);
    assign oe_main    = pd_n;
    assign oe_keep    = 1'b1;
    assign phase_rise = rise_sel;

endmodule

// File: rtl/dual_pixel_formatter.sv
module dual_pixel_formatter
    import pxf_pkg::*;
#(
    parameter bit HAS_STAGGER = 1'b1
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             cfg_dual,
    input  logic             cfg_gate_de,
    input  logic             cfg_stagger_n,
    input  logic             cfg_rise,
    input  logic             drv_pd_n,
    input  logic             in_de,
    input  logic             in_hs,
    input  logic             in_vs,
    input  logic [CTL_W-1:0] in_ctl,
    input  logic [PIX_W-1:0] in_pix,
    output logic [PIX_W-1:0] even_bus,
    output logic [PIX_W-1:0] odd_bus,
    output logic             out_valid,
    output logic             out_de,
    output logic             out_hs,
    output logic             out_vs,
    output logic [CTL_W-1:0] out_ctl,
    output logic             clk_en,
    output logic             phase_rise,
    output logic             oe_main,
    output logic             oe_keep
);

    pxf_in_t   smp;
    pxf_beat_t beat_q;

    assign smp = '{pix: in_pix, de: in_de, hs: in_hs, vs: in_vs, ctl: in_ctl};

    pxf_pairer u_pair (
        .clk    (clk),
        .rst    (rst),
        .dual   (cfg_dual),
        .smp    (smp),
        .beat_q (beat_q)
    );

    pxf_stagger #(.HAS_STAGGER(HAS_STAGGER)) u_stag (
        .clk     (clk),
        .rst     (rst),
        .enable  (cfg_dual && !cfg_stagger_n),
        .odd_in  (beat_q.odd),
        .odd_out (odd_bus)
    );

    pxf_drive u_drv (
        .beat_vld   (beat_q.valid),
        .beat_de    (beat_q.de),
        .gate_de    (cfg_gate_de),
        .pd_n       (drv_pd_n),
        .rise_sel   (cfg_rise),
        .clk_en     (clk_en),
        .oe_main    (oe_main),
        .oe_keep    (oe_keep),
        .phase_rise (phase_rise)
    );

    assign even_bus  = beat_q.even;
    assign out_valid = beat_q.valid;
    assign out_de    = beat_q.de;
    assign out_hs    = beat_q.hs;
    assign out_vs    = beat_q.vs;
    assign out_ctl   = beat_q.ctl;

endmodule

// File: rtl/pxf_chk.sv
module pxf_chk
    import pxf_pkg::*;
(
    input logic             clk,
    input logic             rst,
    input logic             cfg_dual,
    input logic             cfg_gate_de,
    input logic             drv_pd_n,
    input logic             out_valid,
    input logic             out_de,
    input logic [PIX_W-1:0] even_bus,
    input logic [PIX_W-1:0] odd_bus,
    input logic             clk_en,
    input logic             oe_main,
    input logic             oe_keep
);

    // R2: single-pixel mode keeps the odd bus at zero
    a_r2_single_odd_zero: assert property (@(posedge clk) disable iff (rst)
        (!cfg_dual && !$past(cfg_dual)) |-> (odd_bus == '0));

    // R3: in dual mode a beat is never followed directly by another beat
    a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
        (out_valid && cfg_dual && $past(cfg_dual)) |=> !out_valid);

    // R6: a blank beat carries a zero even bus
    a_r6_blank_even_zero: assert property (@(posedge clk) disable iff (rst)
        (out_valid && !out_de) |-> (even_bus == '0));

    // R7: the clock enable only marks beats
    a_r7_clk_en_on_beat: assert property (@(posedge clk) disable iff (rst)
        clk_en |-> out_valid);

    // R7: in gated mode the clock enable needs active video
    a_r7_gated_needs_de: assert property (@(posedge clk) disable iff (rst)
        (clk_en && cfg_gate_de) |-> out_de);

    // R9: power-down drops the main group and keeps the kept group
    a_r9_pd_groups: assert property (@(posedge clk) disable iff (rst)
        !drv_pd_n |-> (!oe_main && oe_keep));

endmodule

bind dual_pixel_formatter pxf_chk u_chk (
    .clk         (clk),
    .rst         (rst),
    .cfg_dual    (cfg_dual),
    .cfg_gate_de (cfg_gate_de),
    .drv_pd_n    (drv_pd_n),
    .out_valid   (out_valid),
    .out_de      (out_de),
    .even_bus    (even_bus),
    .odd_bus     (odd_bus),
    .clk_en      (clk_en),
    .oe_main     (oe_main),
    .oe_keep     (oe_keep)
);

// File: tb/sim_dual_pixel_formatter.sv
`timescale 1ns/1ps
module sim_dual_pixel_formatter;

    localparam time CLK_PERIOD = 10ns;
    localparam int  WATCHDOG   = 200000;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        cfg_dual = 1'b0, cfg_gate_de = 1'b0, cfg_stagger_n = 1'b1, cfg_rise = 1'b1, drv_pd_n = 1'b1;
    logic        in_de = 1'b0, in_hs = 1'b0, in_vs = 1'b0;
    logic [2:0]  in_ctl = '0;
    logic [23:0] in_pix = '0;
    logic [23:0] even_bus, odd_bus;
    logic        out_valid, out_de, out_hs, out_vs, clk_en, phase_rise, oe_main, oe_keep;
    logic [2:0]  out_ctl;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    // expected-state model built from the requirements
    logic        m_ph = 0, m_pde = 0, m_hd = 0, m_val = 0, m_de = 0, m_hs = 0, m_vs = 0;
    logic [23:0] m_hold = '0, m_even = '0, m_odd = '0, m_odd_d = '0;
    logic [2:0]  m_ctl = '0;

    always #(CLK_PERIOD/2) clk = ~clk;

    dual_pixel_formatter u0 (
        .clk(clk), .rst(rst), .cfg_dual(cfg_dual), .cfg_gate_de(cfg_gate_de),
        .cfg_stagger_n(cfg_stagger_n), .cfg_rise(cfg_rise), .drv_pd_n(drv_pd_n),
        .in_de(in_de), .in_hs(in_hs), .in_vs(in_vs), .in_ctl(in_ctl), .in_pix(in_pix),
        .even_bus(even_bus), .odd_bus(odd_bus), .out_valid(out_valid), .out_de(out_de),
        .out_hs(out_hs), .out_vs(out_vs), .out_ctl(out_ctl), .clk_en(clk_en),
        .phase_rise(phase_rise), .oe_main(oe_main), .oe_keep(oe_keep)
    );

    task automatic check(input string req, input string what, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", req, what, act, exp, $time);
        end
    endtask

    // model of one clock edge, from the requirements
    task automatic model_edge(input logic de, input logic [23:0] pix, input logic hs, input logic vs, input logic [2:0] ctl);
        logic rise, beat;
        rise = de && !m_pde;
        beat = cfg_dual ? (rise ? 1'b0 : m_ph) : 1'b1;   // R4 restart
        m_odd_d = m_odd;
        if (beat) begin
            m_val = 1'b1; m_hs = hs; m_vs = vs; m_ctl = ctl;
            if (!cfg_dual) begin
                m_even = de ? pix : '0; m_odd = '0; m_de = de;
            end else if (m_hd) begin
                m_even = m_hold; m_odd = de ? pix : '0; m_de = 1'b1;
            end else begin
                m_even = '0; m_odd = '0; m_de = 1'b0;
            end
            m_hd = 1'b0;
        end else begin
            m_val = 1'b0;
            if (de) begin m_hold = pix; m_hd = 1'b1; end
        end
        m_ph  = cfg_dual ? !beat : 1'b0;
        m_pde = de;
    endtask

    task automatic check_all();
        string md;
        logic [23:0] odd_exp;
        md = cfg_dual ? "R3" : "R2";
        odd_exp = (cfg_dual && !cfg_stagger_n) ? m_odd_d : m_odd;
        check(md, "even_bus", {8'h0, even_bus}, {8'h0, m_even});
        check((cfg_dual && !cfg_stagger_n) ? "R8" : md, "odd_bus", {8'h0, odd_bus}, {8'h0, odd_exp});
        check(md, "out_valid", {31'h0, out_valid}, {31'h0, m_val});
        check(md, "out_de", {31'h0, out_de}, {31'h0, m_de});
        check("R6", "sync_ctl", {27'h0, out_hs, out_vs, out_ctl}, {27'h0, m_hs, m_vs, m_ctl});
        check("R7", "clk_en", {31'h0, clk_en}, {31'h0, m_val && (!cfg_gate_de || m_de)});
        check("R9", "oe", {30'h0, oe_main, oe_keep}, {30'h0, drv_pd_n, 1'b1});
        check("R10", "phase_rise", {31'h0, phase_rise}, {31'h0, cfg_rise});
    endtask

    // drive at the falling edge, model the next rising edge, check at the following falling edge
    task automatic step(input logic de, input logic [23:0] pix);
        logic hs, vs; logic [2:0] ctl;
        hs = 1'($urandom); vs = 1'($urandom); ctl = 3'($urandom);
        in_de = de; in_pix = pix; in_hs = hs; in_vs = vs; in_ctl = ctl;
        model_edge(de, pix, hs, vs, ctl);
        @(negedge clk);
        check_all();
    endtask

    task automatic blank(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 24'($urandom));
    endtask

    task automatic line(input int n);
        for (int i = 0; i < n; i++) step(1'b1, 24'($urandom));
    endtask

    initial begin
        repeat (WATCHDOG) @(posedge clk);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog expired");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed));
        repeat (3) @(negedge clk);
        // R1: reset state while reset is held
        check("R1", "even_bus", {8'h0, even_bus}, 32'h0);
        check("R1", "odd_bus", {8'h0, odd_bus}, 32'h0);
        check("R1", "valid_de_clk", {29'h0, out_valid, out_de, clk_en}, 32'h0);
        check("R1", "sync_ctl", {27'h0, out_hs, out_vs, out_ctl}, 32'h0);
        rst = 1'b0;
        check_all();

        // R2: single-pixel mode
        cfg_dual = 1'b0;
        blank(3); line(5); blank(2); line(1); blank(2);

        // R3, R4, R5: dual mode, single-pixel line after odd-length blank
        cfg_dual = 1'b1;
        blank(3);
        begin
            logic [23:0] px;
            logic [31:0] v_after;
            px = 24'hA5C3E1;
            step(1'b1, px);
            v_after = {31'h0, out_valid};
            check("R4", "first pixel not a beat", v_after, 32'h0);
            step(1'b0, 24'h0);
            check("R5", "trailing even on even_bus", {8'h0, even_bus}, {8'h0, px});
            check("R5", "trailing odd zero", {8'h0, odd_bus}, 32'h0);
            check("R5", "trailing de", {30'h0, out_de, out_valid}, 32'h3);
        end
        blank(2); line(3); blank(4); line(2); blank(1); line(4); blank(3);

        // R7, R8: gated clock enable and staggered odd bus
        cfg_gate_de = 1'b1; cfg_stagger_n = 1'b0;
        line(6); blank(3); line(5); blank(2);
        cfg_dual = 1'b0; blank(1); line(3); blank(2);   // R8 ignored in single mode
        cfg_dual = 1'b1;

        // R9, R10: power-down and phase flag
        drv_pd_n = 1'b0; cfg_rise = 1'b0;
        line(4); blank(2);
        drv_pd_n = 1'b1; cfg_rise = 1'b1;
        blank(1);

        // random segments; mode changes only at blank start
        for (int s = 0; s < 1500; s++) begin
            cfg_dual      = 1'($urandom);
            cfg_gate_de   = 1'($urandom);
            cfg_stagger_n = 1'($urandom);
            cfg_rise      = 1'($urandom);
            drv_pd_n      = ($urandom % 4) != 0;
            blank(1 + int'($urandom % 5));
            line(1 + int'($urandom % 9));
        end
        blank(3);

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule